// File: doc/BRIEF.md
# Lockstep Multi-Stream Clock-Crossing FIFO

This block carries a group of parallel sample streams from a write clock domain into an unrelated read clock domain. All streams are stored side by side in a single shared memory. One occupancy count and one control path serve the whole group, so every stream moves forward by exactly one word on each accepted read. The streams are assumed to be aligned with each other already. For that reason only stream 0 supplies the control signals: valid and sync on the write side, and ready on the read side. Every stream still supplies its own data word.

Write and read pointers cross the clock boundary in Gray code through two-stage synchronizers. The read side reports a fill level. Each output word is the narrow signed input word, sign-extended to a wider output width. A sync marker travels with each entry, and only stream 0's marker is stored. Each domain has its own reset. Each reset is also carried into the opposite domain, so that either reset empties the whole FIFO.

Top module: `mslf_lockstep_fifo`

## Requirements
- R1: On a `wr_clk` edge an entry is stored only when `wr_valid[0]` is 1 and the FIFO is not full. `wr_valid[NS-1:1]` have no effect.
- R2: On a `rd_clk` edge one entry is removed only when `rd_ready[0]` is 1 and the FIFO is not empty. `rd_ready[NS-1:1]` have no effect. Entries leave in the order they were written, and all streams advance together.
- R3: Every bit of `rd_valid` is 1 in the cycle after an accepted read, and 0 in all other cycles.
- R4: When `rd_valid` is 1, the field `rd_data[s*OUT_W +: OUT_W]` holds `wr_data[s*IN_W +: IN_W]` of the matching write, sign-extended from bit IN_W-1.
- R5: When `rd_valid` is 1, every bit of `rd_sync` equals the `wr_sync[0]` of the matching write. When `rd_valid` is 0, `rd_sync` is all 0. `wr_sync[NS-1:1]` have no effect.
- R6: `rd_level` gives the number of entries as seen from the read side, saturating at DEPTH-1. Outside reset it never falls while `rd_ready[0]` is 0, and it never falls by more than one per cycle.
- R7: The FIFO holds DEPTH entries. A write while the FIFO is full is dropped.
- R8: `rd_data` holds its value in every cycle that follows a cycle without `rd_ready[0]`.
- R9: Asserting either `wr_rst` or `rd_rst` discards every stored entry. After release, `rd_level` is 0, `rd_valid` and `rd_sync` are 0, `rd_data` is 0, and only words written afterwards are returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| wr_rst | input | 1 | Synchronous reset, write domain, active high |
| wr_valid | input | NS | Per-stream valid; only bit 0 is used |
| wr_sync | input | NS | Per-stream sync marker; only bit 0 is stored |
| wr_data | input | NS*IN_W | Signed sample of stream s at bits s*IN_W +: IN_W |
| rd_clk | input | 1 | Read-side clock |
| rd_rst | input | 1 | Synchronous reset, read domain, active high |
| rd_ready | input | NS | Per-stream ready; only bit 0 strobes the read |
| rd_valid | output | NS | Output valid, identical on all streams |
| rd_sync | output | NS | Sync marker of the presented entry, on all streams |
| rd_data | output | NS*OUT_W | Sign-extended sample of stream s at bits s*OUT_W +: OUT_W |
| rd_level | output | log2(DEPTH) | Read-side fill count, saturating at DEPTH-1 |

## Verification
The bench builds the block with three streams, 12-bit inputs widened to 16 bits, and a depth of 16. With three streams, the ignored control bits of streams 1 and 2 can be driven against stream 0. The 4-bit widening exposes sign extension on negative samples. The small depth lets a short burst reach the full condition, the dropped writes and the saturated level. The read clock runs at twice the write clock, so in concurrent transfers the FIFO often runs empty, and pointers and resets cross in both directions.

// File: rtl/mslf_pkg.sv
package mslf_pkg;

    // Number of flops in every clock-domain crossing chain.
    localparam int SYNC_STAGES = 2;

    function automatic logic [31:0] bin_to_gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [31:0] gray_to_bin(input logic [31:0] g);
        logic [31:0] b;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) begin
            b[i] = b[i + 1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/mslf_sync.sv
module mslf_sync
    import mslf_pkg::*;
#(
    parameter int   W       = 1,
    parameter logic RST_VAL = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg_d [SYNC_STAGES];
    logic [W-1:0] stg_q [SYNC_STAGES];

    always_comb begin
        stg_d[0] = d;
        for (int k = 1; k < SYNC_STAGES; k++) begin
            stg_d[k] = stg_q[k - 1];
        end
    end

    always_ff @(posedge clk) begin
        for (int k = 0; k < SYNC_STAGES; k++) begin
            if (rst) stg_q[k] <= {W{RST_VAL}};
            else     stg_q[k] <= stg_d[k];
        end
    end

    assign q = stg_q[SYNC_STAGES - 1];

endmodule

// File: rtl/mslf_store.sv
module mslf_store #(
    parameter int WW    = 8,
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          wr_clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [WW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [WW-1:0] rdata
);

    logic [WW-1:0] mem_q [DEPTH];

    always_ff @(posedge wr_clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/mslf_wr_ctrl.sv
module mslf_wr_ctrl
    import mslf_pkg::*;
#(
    parameter int  AW = 6,
    localparam int PW = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push_req,
    input  logic [PW-1:0] rd_gray_s,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [PW-1:0] wr_gray
);

    typedef struct packed {
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
    } wr_st_t;

    wr_st_t st_d, st_q;
    logic   full;

    always_comb begin
        // Full: the pointers differ only in the wrap bit (two top Gray bits inverted).
        full     = (st_q.gray == {~rd_gray_s[PW-1:PW-2], rd_gray_s[PW-3:0]});
        wr_en    = push_req & ~full;
        st_d     = st_q;
        st_d.bin = st_q.bin + PW'(wr_en);
        st_d.gray = PW'(bin_to_gray(32'(st_d.bin)));
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign wr_addr = st_q.bin[AW-1:0];
    assign wr_gray = st_q.gray;

endmodule

// File: rtl/mslf_rd_ctrl.sv
module mslf_rd_ctrl
    import mslf_pkg::*;
#(
    parameter int  NS    = 2,
    parameter int  IN_W  = 16,
    parameter int  OUT_W = 24,
    parameter int  DEPTH = 64,
    localparam int AW    = $clog2(DEPTH),
    localparam int PW    = AW + 1,
    localparam int DW    = NS * IN_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pop_req,
    input  logic [PW-1:0]     wr_gray_s,
    input  logic [DW:0]       rd_word,
    output logic [AW-1:0]     rd_addr,
    output logic [PW-1:0]     rd_gray,
    output logic [NS-1:0]     out_valid,
    output logic [NS-1:0]     out_sync,
    output logic [NS*OUT_W-1:0] out_data,
    output logic [AW-1:0]     level
);

    typedef struct packed {
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
        logic          vld;
        logic          syn;
        logic [DW-1:0] data;
    } rd_st_t;

    rd_st_t        st_d, st_q;
    logic [PW-1:0] wr_bin_s;
    logic [PW-1:0] fill;
    logic          empty;
    logic          pop;

    always_comb begin
        wr_bin_s  = PW'(gray_to_bin(32'(wr_gray_s)));
        empty     = (wr_gray_s == st_q.gray);
        pop       = pop_req & ~empty;
        fill      = wr_bin_s - st_q.bin;
        level     = (fill > PW'(DEPTH - 1)) ? AW'(DEPTH - 1) : fill[AW-1:0];
        st_d      = st_q;
        st_d.bin  = st_q.bin + PW'(pop);
        st_d.gray = PW'(bin_to_gray(32'(st_d.bin)));
        st_d.vld  = pop;
        st_d.syn  = pop & rd_word[DW];
        if (pop) st_d.data = rd_word[DW-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign rd_addr   = st_q.bin[AW-1:0];
    assign rd_gray   = st_q.gray;
    assign out_valid = {NS{st_q.vld}};
    assign out_sync  = {NS{st_q.syn}};

    for (genvar s = 0; s < NS; s++) begin : g_ext
        if (OUT_W > IN_W) begin : g_wide
            assign out_data[s*OUT_W +: OUT_W] =
                {{(OUT_W - IN_W){st_q.data[s*IN_W + IN_W - 1]}}, st_q.data[s*IN_W +: IN_W]};
        end else begin : g_same
            assign out_data[s*OUT_W +: OUT_W] = st_q.data[s*IN_W +: OUT_W];
        end
    end

endmodule

// File: rtl/mslf_lockstep_fifo.sv
module mslf_lockstep_fifo #(
    parameter int  NS    = 2,
    parameter int  IN_W  = 16,
    parameter int  OUT_W = 24,
    parameter int  DEPTH = 64,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic                wr_clk,
    input  logic                wr_rst,
    input  logic [NS-1:0]       wr_valid,
    input  logic [NS-1:0]       wr_sync,
    input  logic [NS*IN_W-1:0]  wr_data,
    input  logic                rd_clk,
    input  logic                rd_rst,
    input  logic [NS-1:0]       rd_ready,
    output logic [NS-1:0]       rd_valid,
    output logic [NS-1:0]       rd_sync,
    output logic [NS*OUT_W-1:0] rd_data,
    output logic [AW-1:0]       rd_level
);

    localparam int PW = AW + 1;
    localparam int WW = NS * IN_W + 1;

    logic          rd_rst_w, wr_lrst, wr_lrst_r, rd_lrst;
    logic          wr_en;
    logic [AW-1:0] wr_addr, rd_addr;
    logic [PW-1:0] wr_gray, wr_gray_s, rd_gray, rd_gray_s;
    logic [WW-1:0] rd_word;

    // Reset coupling: the read reset reaches the write side, and the
    // combined write reset is echoed back, so either reset empties both.
    mslf_sync #(.W(1), .RST_VAL(1'b1)) u_rst_r2w (
        .clk(wr_clk), .rst(wr_rst), .d(rd_rst), .q(rd_rst_w));
    assign wr_lrst = wr_rst | rd_rst_w;

    mslf_sync #(.W(1), .RST_VAL(1'b1)) u_rst_w2r (
        .clk(rd_clk), .rst(rd_rst), .d(wr_lrst), .q(wr_lrst_r));
    assign rd_lrst = rd_rst | wr_lrst_r;

    mslf_sync #(.W(PW), .RST_VAL(1'b0)) u_wptr_sync (
        .clk(rd_clk), .rst(rd_lrst), .d(wr_gray), .q(wr_gray_s));

    mslf_sync #(.W(PW), .RST_VAL(1'b0)) u_rptr_sync (
        .clk(wr_clk), .rst(wr_lrst), .d(rd_gray), .q(rd_gray_s));

    mslf_wr_ctrl #(.AW(AW)) u_wr (
        .clk(wr_clk), .rst(wr_lrst), .push_req(wr_valid[0]),
        .rd_gray_s(rd_gray_s), .wr_en(wr_en), .wr_addr(wr_addr), .wr_gray(wr_gray));

    mslf_store #(.WW(WW), .DEPTH(DEPTH)) u_mem (
        .wr_clk(wr_clk), .we(wr_en), .waddr(wr_addr),
        .wdata({wr_sync[0], wr_data}), .raddr(rd_addr), .rdata(rd_word));

    mslf_rd_ctrl #(.NS(NS), .IN_W(IN_W), .OUT_W(OUT_W), .DEPTH(DEPTH)) u_rd (
        .clk(rd_clk), .rst(rd_lrst), .pop_req(rd_ready[0]),
        .wr_gray_s(wr_gray_s), .rd_word(rd_word), .rd_addr(rd_addr),
        .rd_gray(rd_gray), .out_valid(rd_valid), .out_sync(rd_sync),
        .out_data(rd_data), .level(rd_level));

endmodule

// File: rtl/mslf_chk.sv
module mslf_chk #(
    parameter int NS    = 2,
    parameter int OUT_W = 24,
    parameter int AW    = 6
) (
    input logic                rd_clk,
    input logic                rd_rst,
    input logic                wr_rst,
    input logic [NS-1:0]       rd_ready,
    input logic [NS-1:0]       rd_valid,
    input logic [NS-1:0]       rd_sync,
    input logic [NS*OUT_W-1:0] rd_data,
    input logic [AW-1:0]       rd_level
);

    // R3: output valid only follows a cycle with ready on stream 0
    assert_rd_after_ready_R3: assert property (@(posedge rd_clk) disable iff (rd_rst || wr_rst)
        rd_valid[0] |-> $past(rd_ready[0]));

    // R5: sync marker is only shown with valid
    assert_sync_qual_R5: assert property (@(posedge rd_clk) disable iff (rd_rst || wr_rst)
        rd_sync[0] |-> rd_valid[0]);

    // R6: without a read the level does not fall
    assert_level_hold_R6: assert property (@(posedge rd_clk) disable iff (rd_rst || wr_rst)
        !$past(rd_ready[0]) |-> (rd_level >= $past(rd_level)));

    // R6: the level falls by at most one per cycle
    assert_level_step_R6: assert property (@(posedge rd_clk) disable iff (rd_rst || wr_rst)
        (32'(rd_level) + 32'd1) >= 32'($past(rd_level)));

    // R8: data holds when no read was requested
    assert_data_hold_R8: assert property (@(posedge rd_clk) disable iff (rd_rst || wr_rst)
        !$past(rd_ready[0]) |-> $stable(rd_data));

    // R9: right after a read reset, level and valid are cleared
    assert_reset_clear_R9: assert property (@(posedge rd_clk) disable iff (rd_rst)
        $fell(rd_rst) |-> (rd_level == '0 && rd_valid == '0));

endmodule

bind mslf_lockstep_fifo mslf_chk #(.NS(NS), .OUT_W(OUT_W), .AW(AW)) u_chk (
    .rd_clk(rd_clk), .rd_rst(rd_rst), .wr_rst(wr_rst), .rd_ready(rd_ready),
    .rd_valid(rd_valid), .rd_sync(rd_sync), .rd_data(rd_data), .rd_level(rd_level));

// File: tb/sim_mslf_lockstep_fifo.sv
module sim_mslf_lockstep_fifo;

    localparam int NS    = 3;
    localparam int IN_W  = 12;
    localparam int OUT_W = 16;
    localparam int DEPTH = 16;
    localparam int AW    = $clog2(DEPTH);

    logic                wr_clk = 1'b0, rd_clk = 1'b0;
    logic                wr_rst = 1'b1, rd_rst = 1'b1;
    logic [NS-1:0]       wr_valid = '0, wr_sync = '0, rd_ready = '0;
    logic [NS*IN_W-1:0]  wr_data = '0;
    logic [NS-1:0]       rd_valid, rd_sync;
    logic [NS*OUT_W-1:0] rd_data;
    logic [AW-1:0]       rd_level;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2ns rd_clk = ~rd_clk;
    always #4ns wr_clk = ~wr_clk;

    mslf_lockstep_fifo #(.NS(NS), .IN_W(IN_W), .OUT_W(OUT_W), .DEPTH(DEPTH)) u0 (
        .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_valid(wr_valid), .wr_sync(wr_sync),
        .wr_data(wr_data), .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_ready(rd_ready),
        .rd_valid(rd_valid), .rd_sync(rd_sync), .rd_data(rd_data), .rd_level(rd_level));

    function automatic logic [IN_W-1:0] val(int i, int s);
        int v;
        v = i * 613 + s * 1371 + 5;
        if (i % 2 == 1) v = v ^ (1 << (IN_W - 1));
        return IN_W'(v);
    endfunction

    function automatic logic [NS*OUT_W-1:0] exp_data(int i);
        logic [NS*OUT_W-1:0] r;
        for (int s = 0; s < NS; s++) begin
            logic [IN_W-1:0] v;
            v = val(i, s);
            r[s*OUT_W +: OUT_W] = {{(OUT_W - IN_W){v[IN_W-1]}}, v};
        end
        return r;
    endfunction

    function automatic logic exp_sync(int i);
        return (i % 4) == 0;
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_rd(input int n);
        for (int k = 0; k < n; k++) @(negedge rd_clk);
    endtask

    // Writes words start..start+n-1; sync set on stream 0 only.
    task automatic wr_words(input int start, input int n);
        for (int i = start; i < start + n; i++) begin
            @(negedge wr_clk);
            wr_valid = '1;
            wr_sync  = {{(NS-1){1'b0}}, exp_sync(i)};
            for (int s = 0; s < NS; s++) wr_data[s*IN_W +: IN_W] = val(i, s);
        end
        @(negedge wr_clk);
        wr_valid = '0;
        wr_sync  = '0;
    endtask

    task automatic drain(input int start, input int n, input string tag);
        int got = 0;
        int idle = 0;
        int extra = 0;
        @(negedge rd_clk);
        rd_ready = {{(NS-1){1'b0}}, 1'b1};
        while (got < n && idle < 300) begin
            @(negedge rd_clk);
            if (rd_valid[0]) begin
                check(rd_valid == '1, "R3", 64'(rd_valid), 64'({NS{1'b1}}));
                check(rd_data == exp_data(start + got), {tag, " R4"}, 64'(rd_data), 64'(exp_data(start + got)));
                check(rd_sync == {NS{exp_sync(start + got)}}, "R5", 64'(rd_sync), 64'({NS{exp_sync(start + got)}}));
                got++;
                idle = 0;
            end else begin
                idle++;
            end
        end
        for (int k = 0; k < 6; k++) begin
            @(negedge rd_clk);
            if (rd_valid != '0) extra++;
        end
        rd_ready = '0;
        check(got == n, {tag, " R2 count"}, 64'(got), 64'(n));
        check(extra == 0, {tag, " R7 no extra"}, 64'(extra), 64'd0);
    endtask

    task automatic t_reset;
        wr_rst = 1'b1;
        rd_rst = 1'b1;
        wait_rd(20);
        wr_rst = 1'b0;
        rd_rst = 1'b0;
        wait_rd(20);
        check(rd_level == '0, "R9 level", 64'(rd_level), 64'd0);
        check(rd_valid == '0, "R9 valid", 64'(rd_valid), 64'd0);
        check(rd_data == '0, "R9 data", 64'(rd_data), 64'd0);
        check(rd_sync == '0, "R9 sync", 64'(rd_sync), 64'd0);
    endtask

    task automatic t_basic;
        wr_words(0, 5);
        wait_rd(12);
        check(rd_level == AW'(5), "R6 level", 64'(rd_level), 64'd5);
        check(rd_valid == '0, "R3 idle", 64'(rd_valid), 64'd0);
        drain(0, 5, "basic");
        check(rd_data == exp_data(4), "R8 hold", 64'(rd_data), 64'(exp_data(4)));
        check(rd_sync == '0, "R5 idle", 64'(rd_sync), 64'd0);
        check(rd_level == '0, "R6 empty", 64'(rd_level), 64'd0);
    endtask

    task automatic t_ignore;
        // R1: valid on streams 1 and 2 only stores nothing
        for (int k = 0; k < 4; k++) begin
            @(negedge wr_clk);
            wr_valid = {{(NS-1){1'b1}}, 1'b0};
            wr_sync  = {{(NS-1){1'b1}}, 1'b0};
        end
        @(negedge wr_clk);
        wr_valid = '0;
        wait_rd(12);
        check(rd_level == '0, "R1 ignored valid", 64'(rd_level), 64'd0);
        // R5: one word whose sync is set on streams 1,2 but not 0
        @(negedge wr_clk);
        wr_valid = {{(NS-1){1'b0}}, 1'b1};
        wr_sync  = {{(NS-1){1'b1}}, 1'b0};
        for (int s = 0; s < NS; s++) wr_data[s*IN_W +: IN_W] = val(101, s);
        @(negedge wr_clk);
        wr_valid = '0;
        wr_sync  = '0;
        wait_rd(12);
        check(rd_level == AW'(1), "R1 stream0 valid", 64'(rd_level), 64'd1);
        // R2: ready on streams 1,2 only removes nothing
        @(negedge rd_clk);
        rd_ready = {{(NS-1){1'b1}}, 1'b0};
        wait_rd(8);
        check(rd_valid == '0, "R2 ignored ready", 64'(rd_valid), 64'd0);
        check(rd_level == AW'(1), "R2 ignored ready level", 64'(rd_level), 64'd1);
        rd_ready = '0;
        drain(101, 1, "ignore");
    endtask

    task automatic t_stream;
        fork
            wr_words(200, 25);
            drain(200, 25, "stream");
        join
    endtask

    task automatic t_full;
        wr_words(400, DEPTH + 4);
        wait_rd(12);
        check(rd_level == AW'(DEPTH - 1), "R6 R7 saturate", 64'(rd_level), 64'(DEPTH - 1));
        drain(400, DEPTH, "full R7");
    endtask

    task automatic t_wr_reset;
        wr_words(300, 3);
        wait_rd(12);
        check(rd_level == AW'(3), "R6 before wr reset", 64'(rd_level), 64'd3);
        @(negedge wr_clk);
        wr_rst = 1'b1;
        for (int k = 0; k < 8; k++) @(negedge wr_clk);
        wr_rst = 1'b0;
        wait_rd(20);
        check(rd_level == '0, "R9 wr reset level", 64'(rd_level), 64'd0);
        check(rd_valid == '0, "R9 wr reset valid", 64'(rd_valid), 64'd0);
        wr_words(310, 2);
        wait_rd(12);
        drain(310, 2, "wr reset R9");
    endtask

    task automatic t_rd_reset;
        wr_words(500, 3);
        wait_rd(12);
        check(rd_level == AW'(3), "R6 before rd reset", 64'(rd_level), 64'd3);
        @(negedge rd_clk);
        rd_rst = 1'b1;
        wait_rd(16);
        rd_rst = 1'b0;
        wait_rd(20);
        check(rd_level == '0, "R9 rd reset level", 64'(rd_level), 64'd0);
        check(rd_data == '0, "R9 rd reset data", 64'(rd_data), 64'd0);
        wr_words(520, 2);
        wait_rd(12);
        drain(520, 2, "rd reset R9");
    endtask

    initial begin
        t_reset();
        t_basic();
        t_ignore();
        t_stream();
        t_full();
        t_wr_reset();
        t_rd_reset();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #300us;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule